// File: doc/BRIEF.md
# Active-Low Bus Parity Generator and Checker

This block produces and checks parity for two groups of active-low bus signals. The request group is a strobe bit plus a request code, and its parity comes from whichever agent starts the request. The response group is a response status field, and its parity comes from the agent that completes the transaction. All signals are handled at their electrical levels, where low means asserted. The parity pin reads high when an even number of the covered pins are low, and low when an odd number are low. As a result, an idle group with every pin high also has its parity pin high.

Each group has a generator and a checker. The generator is used when this agent drives the group. It registers the covered pins and their parity together, so both appear on the bus in the same clock. The response generator does not drive while the status is all-deasserted, because that encoding means no agent is driving. In that case it leaves the pins and the parity line at their high idle level.

The checker is used when this agent receives the group. It samples the pins and the parity line only on cycles where its valid qualifier is high. On a mismatch it raises an error flag for one clock. All pins are plain level signals with no back-pressure: the bus moves one sample per cycle and nothing can be stalled.

Top module: `lowpar_bus_guard`

## Requirements
- R1: While reset is low and on the first edge after it, every driven pin and parity output is high, both output enables are low and both error flags are low.
- R2: One clock after an edge at which `req_drv_i` is high, the request outputs equal the sampled strobe and code, `req_oe_o` is high, and `req_par_o` is high exactly when an even number of those six pins are low.
- R3: A request with all six pins high (nothing asserted) is driven with `req_par_o` high.
- R4: One clock after an edge at which a generator's drive input is low, its pins and parity are all high and its output enable is low.
- R5: One clock after an edge at which `rsp_drv_i` is high and the status is not 3'b111, the status is copied to `rsp_stat_n_o`, `rsp_oe_o` is high, and `rsp_par_o` is high exactly when an even number of the three status pins are low.
- R6: A response status of 3'b111 (encoding 000, all deasserted) is treated as idle: even with `rsp_drv_i` high, `rsp_oe_o` stays low and `rsp_stat_n_o` and `rsp_par_o` read high.
- R7: One clock after an edge at which `req_mon_vld_i` is high, `req_perr_o` is high exactly when `req_mon_par_i` differs from the even-low parity of the monitored strobe and code.
- R8: Samples taken while a checker's valid input is low never raise its error flag, whatever the parity.
- R9: The response checker applies the same rule as the request checker. An idle 3'b111 status with parity high passes, and an idle status with parity low is flagged.
- R10: Each flag is high for exactly one clock per mismatching valid sample. Back-to-back bad samples keep it high, and it returns low after the first good or unqualified sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_drv_i | input | 1 | This agent drives the request group this cycle |
| req_strb_n_i | input | 1 | Strobe level to drive (low = asserted) |
| req_code_n_i | input | CODE_W | Request code levels to drive |
| req_strb_n_o | output | 1 | Registered strobe pin level |
| req_code_n_o | output | CODE_W | Registered request code pin levels |
| req_par_o | output | 1 | Registered request parity pin level |
| req_oe_o | output | 1 | Request group output enable |
| rsp_drv_i | input | 1 | This agent drives the response group this cycle |
| rsp_stat_n_i | input | STAT_W | Response status levels to drive |
| rsp_stat_n_o | output | STAT_W | Registered response status pin levels |
| rsp_par_o | output | 1 | Registered response parity pin level |
| rsp_oe_o | output | 1 | Response group output enable |
| req_mon_vld_i | input | 1 | Qualifier for the monitored request group |
| req_mon_strb_n_i | input | 1 | Monitored strobe level |
| req_mon_code_n_i | input | CODE_W | Monitored request code levels |
| req_mon_par_i | input | 1 | Monitored request parity level |
| req_perr_o | output | 1 | One-clock request parity error flag |
| rsp_mon_vld_i | input | 1 | Qualifier for the monitored response group |
| rsp_mon_stat_n_i | input | STAT_W | Monitored response status levels |
| rsp_mon_par_i | input | 1 | Monitored response parity level |
| rsp_perr_o | output | 1 | One-clock response parity error flag |

## Verification
On every cycle, the assertions check four things. Any driven parity matches a count of the low pins. A disabled generator sits at the all-high idle level. The response generator never enables on the idle status. An error flag follows only from a qualified mismatching sample, and a qualified mismatch always produces one. Only the bench scenarios can show the rest. These include the exact pin values copied through the generators and the hand-computed parity of specific patterns such as all-low or single-low codes. They also include the one-clock length of an error flag across back-to-back bad samples, and the behaviour across a reset taken in the middle of a run.

// File: rtl/lowpar_pkg.sv
package lowpar_pkg;
  localparam int unsigned REQ_CODE_W = 5;
  localparam int unsigned RSP_STAT_W = 3;
endpackage

// File: rtl/lowpar_calc.sv
module lowpar_calc #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] pins_n_i,
  output logic         par_o
);
  // Count of low pins is the XOR of inverted levels; even count -> high.
  logic [W-1:0] low_mask;
  assign low_mask = ~pins_n_i;
  assign par_o    = ~(^low_mask);
endmodule

// File: rtl/lowpar_gen.sv
module lowpar_gen #(
  parameter int unsigned W           = 6,
  parameter bit          IDLE_EXEMPT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drv_i,
  input  logic [W-1:0] pins_n_i,
  output logic [W-1:0] pins_n_o,
  output logic         par_o,
  output logic         oe_o
);
  logic par_d;
  logic idle_pat;
  logic drive_d;

  lowpar_calc #(.W(W)) u_calc (
    .pins_n_i (pins_n_i),
    .par_o    (par_d)
  );

  assign idle_pat = &pins_n_i;
  assign drive_d  = drv_i && (!IDLE_EXEMPT || !idle_pat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_n_o <= '1;
      par_o    <= 1'b1;
      oe_o     <= 1'b0;
    end else if (drive_d) begin
      pins_n_o <= pins_n_i;
      par_o    <= par_d;
      oe_o     <= 1'b1;
    end else begin
      pins_n_o <= '1;
      par_o    <= 1'b1;
      oe_o     <= 1'b0;
    end
  end

  // R2 / R5: driven parity agrees with a count of low pins
  a_r2_par_even_lows: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> (par_o == ($countones(~pins_n_o) % 2 == 0)));

  // R4: undriven group rests at all-high
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> ((&pins_n_o) && par_o));

  // R4: drive input low disables on the next clock
  a_r4_drop_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_i |=> !oe_o);

  generate
    if (IDLE_EXEMPT) begin : g_exempt
      // R6: idle status is never actively driven
      a_r6_no_idle_drive: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> !(&pins_n_o));
    end
  endgenerate
endmodule

// File: rtl/lowpar_chk.sv
module lowpar_chk #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] pins_n_i,
  input  logic         par_i,
  output logic         err_o
);
  logic par_exp;

  lowpar_calc #(.W(W)) u_calc (
    .pins_n_i (pins_n_i),
    .par_o    (par_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= vld_i && (par_i != par_exp);
  end

  // R8: a flag only follows a qualified sample
  a_r8_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(vld_i));

  // R7 / R9: qualified mismatch by count always flags next clock
  a_r7_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && (par_i != ($countones(~pins_n_i) % 2 == 0))) |=> err_o);

  // R10: qualified match clears the flag next clock
  a_r10_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && (par_i == ($countones(~pins_n_i) % 2 == 0))) |=> !err_o);
endmodule

// File: rtl/lowpar_bus_guard.sv
module lowpar_bus_guard
  import lowpar_pkg::*;
#(
  parameter int unsigned CODE_W = REQ_CODE_W,
  parameter int unsigned STAT_W = RSP_STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_drv_i,
  input  logic              req_strb_n_i,
  input  logic [CODE_W-1:0] req_code_n_i,
  output logic              req_strb_n_o,
  output logic [CODE_W-1:0] req_code_n_o,
  output logic              req_par_o,
  output logic              req_oe_o,
  input  logic              rsp_drv_i,
  input  logic [STAT_W-1:0] rsp_stat_n_i,
  output logic [STAT_W-1:0] rsp_stat_n_o,
  output logic              rsp_par_o,
  output logic              rsp_oe_o,
  input  logic              req_mon_vld_i,
  input  logic              req_mon_strb_n_i,
  input  logic [CODE_W-1:0] req_mon_code_n_i,
  input  logic              req_mon_par_i,
  output logic              req_perr_o,
  input  logic              rsp_mon_vld_i,
  input  logic [STAT_W-1:0] rsp_mon_stat_n_i,
  input  logic              rsp_mon_par_i,
  output logic              rsp_perr_o
);
  localparam int unsigned REQ_W = CODE_W + 1;

  logic [REQ_W-1:0] req_pins_q;

  lowpar_gen #(.W(REQ_W), .IDLE_EXEMPT(1'b0)) u_req_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .drv_i    (req_drv_i),
    .pins_n_i ({req_strb_n_i, req_code_n_i}),
    .pins_n_o (req_pins_q),
    .par_o    (req_par_o),
    .oe_o     (req_oe_o)
  );

  assign req_strb_n_o = req_pins_q[REQ_W-1];
  assign req_code_n_o = req_pins_q[CODE_W-1:0];

  lowpar_gen #(.W(STAT_W), .IDLE_EXEMPT(1'b1)) u_rsp_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .drv_i    (rsp_drv_i),
    .pins_n_i (rsp_stat_n_i),
    .pins_n_o (rsp_stat_n_o),
    .par_o    (rsp_par_o),
    .oe_o     (rsp_oe_o)
  );

  lowpar_chk #(.W(REQ_W)) u_req_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_i    (req_mon_vld_i),
    .pins_n_i ({req_mon_strb_n_i, req_mon_code_n_i}),
    .par_i    (req_mon_par_i),
    .err_o    (req_perr_o)
  );

  lowpar_chk #(.W(STAT_W)) u_rsp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_i    (rsp_mon_vld_i),
    .pins_n_i (rsp_mon_stat_n_i),
    .par_i    (rsp_mon_par_i),
    .err_o    (rsp_perr_o)
  );

  // R1: both flags clear on the first edge after reset
  a_r1_flags_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!req_perr_o && !rsp_perr_o && !req_oe_o && !rsp_oe_o));
endmodule

// File: tb/lowpar_bus_guard_tb.sv
`timescale 1ns/1ps
module lowpar_bus_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_drv_i = 0, req_strb_n_i = 1;
  logic [4:0] req_code_n_i = '1;
  logic       req_strb_n_o, req_par_o, req_oe_o;
  logic [4:0] req_code_n_o;
  logic       rsp_drv_i = 0;
  logic [2:0] rsp_stat_n_i = '1;
  logic [2:0] rsp_stat_n_o;
  logic       rsp_par_o, rsp_oe_o;
  logic       req_mon_vld_i = 0, req_mon_strb_n_i = 1, req_mon_par_i = 1;
  logic [4:0] req_mon_code_n_i = '1;
  logic       req_perr_o;
  logic       rsp_mon_vld_i = 0, rsp_mon_par_i = 1;
  logic [2:0] rsp_mon_stat_n_i = '1;
  logic       rsp_perr_o;

  lowpar_bus_guard u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_drv_i(req_drv_i), .req_strb_n_i(req_strb_n_i), .req_code_n_i(req_code_n_i),
    .req_strb_n_o(req_strb_n_o), .req_code_n_o(req_code_n_o),
    .req_par_o(req_par_o), .req_oe_o(req_oe_o),
    .rsp_drv_i(rsp_drv_i), .rsp_stat_n_i(rsp_stat_n_i),
    .rsp_stat_n_o(rsp_stat_n_o), .rsp_par_o(rsp_par_o), .rsp_oe_o(rsp_oe_o),
    .req_mon_vld_i(req_mon_vld_i), .req_mon_strb_n_i(req_mon_strb_n_i),
    .req_mon_code_n_i(req_mon_code_n_i), .req_mon_par_i(req_mon_par_i),
    .req_perr_o(req_perr_o),
    .rsp_mon_vld_i(rsp_mon_vld_i), .rsp_mon_stat_n_i(rsp_mon_stat_n_i),
    .rsp_mon_par_i(rsp_mon_par_i), .rsp_perr_o(rsp_perr_o)
  );

  // {strobe, code[4:0]} levels, expected parity (hand counted low pins)
  localparam logic [6:0] REQ_TAB [8] = '{
    {6'b111111, 1'b1}, {6'b011111, 1'b0}, {6'b000000, 1'b1}, {6'b101010, 1'b0},
    {6'b110011, 1'b1}, {6'b000001, 1'b0}, {6'b011110, 1'b1}, {6'b100000, 1'b0}
  };
  // {status[2:0] levels, expected parity, expected output enable}
  localparam logic [4:0] RSP_TAB [8] = '{
    {3'b111, 1'b1, 1'b0}, {3'b110, 1'b0, 1'b1}, {3'b101, 1'b0, 1'b1}, {3'b011, 1'b0, 1'b1},
    {3'b100, 1'b1, 1'b1}, {3'b001, 1'b1, 1'b1}, {3'b000, 1'b0, 1'b1}, {3'b010, 1'b1, 1'b1}
  };

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 req pins/par/oe", {req_strb_n_o, req_code_n_o, req_par_o, req_oe_o}, 8'b1111_1110);
    check("R1 rsp pins/par/oe", {rsp_stat_n_o, rsp_par_o, rsp_oe_o}, 8'b0001_1110);
    check("R1 flags", {req_perr_o, rsp_perr_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {req_oe_o, rsp_oe_o, req_perr_o, rsp_perr_o}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      req_drv_i = 1; {req_strb_n_i, req_code_n_i} = REQ_TAB[i][6:1];
      rsp_drv_i = 1; rsp_stat_n_i = RSP_TAB[i][4:2];
      req_mon_vld_i = 1; {req_mon_strb_n_i, req_mon_code_n_i} = REQ_TAB[i][6:1];
      req_mon_par_i = REQ_TAB[i][0];
      rsp_mon_vld_i = 1; rsp_mon_stat_n_i = RSP_TAB[i][4:2];
      rsp_mon_par_i = RSP_TAB[i][1];
      @(negedge clk);
      // R2 / R3 request generator
      check("R2 req pins", {2'b00, req_strb_n_o, req_code_n_o}, {2'b00, REQ_TAB[i][6:1]});
      check("R2 R3 req parity", {7'b0, req_par_o}, {7'b0, REQ_TAB[i][0]});
      check("R2 req oe", {7'b0, req_oe_o}, 8'h01);
      // R5 / R6 response generator
      check("R5 R6 rsp pins", {5'b0, rsp_stat_n_o},
            {5'b0, (RSP_TAB[i][0] ? RSP_TAB[i][4:2] : 3'b111)});
      check("R5 R6 rsp parity/oe", {6'b0, rsp_par_o, rsp_oe_o}, {6'b0, RSP_TAB[i][1:0]});
      // R7 / R9 good parity passes
      check("R7 R9 no flag on match", {6'b0, req_perr_o, rsp_perr_o}, 8'h00);
      req_mon_par_i = ~REQ_TAB[i][0];
      rsp_mon_par_i = ~RSP_TAB[i][1];
      @(negedge clk);
      check("R7 req flag on mismatch", {7'b0, req_perr_o}, 8'h01);
      check("R9 rsp flag on mismatch", {7'b0, rsp_perr_o}, 8'h01);
    end

    // R8: unqualified wrong parity ignored
    req_mon_vld_i = 0; rsp_mon_vld_i = 0;
    req_mon_par_i = 1'b0; {req_mon_strb_n_i, req_mon_code_n_i} = 6'b111111;
    rsp_mon_par_i = 1'b0; rsp_mon_stat_n_i = 3'b111;
    @(negedge clk);
    check("R8 no flag without valid", {6'b0, req_perr_o, rsp_perr_o}, 8'h00);

    // R10: back-to-back bad samples, then a good one
    req_mon_vld_i = 1; rsp_mon_vld_i = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 consecutive flags", {6'b0, req_perr_o, rsp_perr_o}, 8'h03);
    end
    req_mon_par_i = 1'b1; rsp_mon_par_i = 1'b1;
    @(negedge clk);
    check("R10 R9 flag drops, idle status passes", {6'b0, req_perr_o, rsp_perr_o}, 8'h00);

    // R4: drive inputs low
    req_drv_i = 1; {req_strb_n_i, req_code_n_i} = 6'b000000;
    rsp_drv_i = 1; rsp_stat_n_i = 3'b000;
    @(negedge clk);
    req_drv_i = 0; rsp_drv_i = 0;
    @(negedge clk);
    check("R4 req released", {req_strb_n_o, req_code_n_o, req_par_o, req_oe_o}, 8'b1111_1110);
    check("R4 rsp released", {3'b000, rsp_stat_n_o, rsp_par_o, rsp_oe_o}, 8'b0001_1110);

    // R1: reset mid-run clears a pending flag and drive
    req_drv_i = 1; rsp_drv_i = 1; rsp_stat_n_i = 3'b010;
    req_mon_par_i = 1'b0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R1 mid-run reset", {4'b0, req_oe_o, rsp_oe_o, req_perr_o, rsp_perr_o}, 8'h00);
    finish_run();
  end
endmodule